// File: doc/BRIEF.md
# Core and System Clock Ratio Controller

This block derives two clock-enable streams, one for a processor core and one for the system bus and peripherals, from a fast reference clock. Inside it, an ideal frequency synthesizer is modelled as a phase accumulator. The block produces an input-clock tick once every 2^MULT_W reference cycles. It also produces a multiplied tick at `multSel` times that rate. A core divider and a system divider count these multiplied ticks and emit single-cycle enables. These enables are meant to drive clock-gating cells in the core and system domains.

The two dividers are programmed independently. The system divider can only end its period on a core pulse, so the system rate can never exceed the core rate, and each system pulse lands on a core pulse. A bypass setting skips the multiplier and the core divider, so that the core enable follows the input-clock tick.

Settings may be changed at any time. They are captured only at the end of the current system period, when both dividers wrap together, so no period is ever cut short. While reset is held, the settings present at the inputs are captured directly.

Top module: `crc_ratio_ctrl`

## Requirements
- R1: While `rstN` is low (synchronous, active low), `coreEn` and `sysEn` are 0 in the cycle after each reset edge. The settings on the inputs are captured as the applied settings.
- R2: Out of bypass, the multiplied tick fires exactly `multSel` times in every window of 2^MULT_W (32) consecutive reference cycles. A `multSel` of 0 acts as 1. With a core divide of 1, `coreEn` therefore pulses `multSel` times per 32 cycles.
- R3: Out of bypass, `coreEn` pulses once every `divCoreSel` multiplied ticks. A `divCoreSel` of 0 acts as 1.
- R4: The system period, in base ticks, is the smallest multiple of the core divide that is not below `divSysSel` (0 acts as 1). The system rate is thus never above the core rate.
- R5: Every cycle with `sysEn` high also has `coreEn` high.
- R6: `sysClamped` is 1 exactly when the applied settings are out of bypass and the applied system divide is smaller than the applied core divide.
- R7: In bypass, the base tick is the input-clock tick and the core divide is 1, so `coreEn` equals `refTick` in every cycle. The system divide then counts input-clock ticks.
- R8: New settings take effect only at the end of a system period, in the cycle after `sysEn`'s source strobe. A change made mid-period leaves the running period and its rate untouched.
- R9: All outputs are registered, so each enable appears one reference cycle after the tick that produced it. `refTick` has the same one-cycle delay, so that in bypass it lines up with `coreEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| multSel | input | MULT_W (5) | Multiplier setting, 1..31 (0 acts as 1) |
| divCoreSel | input | DIV_W (4) | Core divider setting (0 acts as 1) |
| divSysSel | input | DIV_W (4) | System divider setting (0 acts as 1) |
| bypassSel | input | 1 | 1 routes the input-clock tick straight to the core enable |
| coreEn | output | 1 | Core clock-enable pulse |
| sysEn | output | 1 | System clock-enable pulse |
| refTick | output | 1 | Input-clock tick, one pulse per 2^MULT_W cycles |
| sysClamped | output | 1 | System divide is held up by the core divide |

## Verification
The assertions assume that reset is held low for at least one clock edge before the first check. The hold-the-settings property depends on it.

They do not assume the inputs are stable. Setting changes may come at any cycle, because the capture logic is what they guard. The stimulus changes settings on falling edges, sometimes in the middle of a system period, and holds the inputs constant throughout reset.

// File: rtl/crc_pkg.sv
package crc_pkg;

  // Strobes issued by the control counters to the datapath registers.
  typedef struct packed {
    logic coreFire;  // core divider wraps this cycle
    logic sysFire;   // system divider wraps this cycle
    logic loadCfg;   // capture new settings at this boundary
    logic refFire;   // input-clock tick this cycle
  } strobe_t;

endpackage

// File: rtl/crc_tickgen.sv
module crc_tickgen #(
  parameter int MULT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MULT_W-1:0] multQ,
  output logic              refTick,
  output logic              pllTick
);

  logic [MULT_W-1:0] phaseQ;
  logic [MULT_W-1:0] accQ;
  logic [MULT_W:0]   accSum;

  // Input clock: one tick per full turn of the phase counter.
  // Multiplied clock: carry out of an accumulator stepping by multQ.
  assign accSum  = {1'b0, accQ} + {1'b0, multQ};
  assign pllTick = accSum[MULT_W];
  assign refTick = &phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      accQ   <= '0;
    end else begin
      phaseQ <= phaseQ + MULT_W'(1);
      accQ   <= accSum[MULT_W-1:0];
    end
  end

  // R2: input ticks are spaced a full phase turn apart
  a_r2_ref_spacing: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> !refTick);

endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             pllTick,
  input  logic [DIV_W-1:0] divAQ,
  input  logic [DIV_W-1:0] divBQ,
  input  logic             bypassQ,
  output strobe_t          strobes
);

  localparam int CNT_W = DIV_W + 1;

  logic             baseTick;
  logic [DIV_W-1:0] effA;
  logic [DIV_W-1:0] coreCntQ;
  logic [CNT_W-1:0] sysCntQ;
  logic [CNT_W-1:0] sysNext;
  logic             coreFire;
  logic             sysFire;

  always_comb begin
    baseTick = bypassQ ? refTick : pllTick;
    effA     = bypassQ ? DIV_W'(1) : divAQ;
    coreFire = baseTick && (coreCntQ == effA - DIV_W'(1));
    sysNext  = sysCntQ + CNT_W'(1);
    // system period may only close on a core pulse
    sysFire  = coreFire && (sysNext >= {1'b0, divBQ});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreCntQ <= '0;
      sysCntQ  <= '0;
    end else if (baseTick) begin
      coreCntQ <= coreFire ? '0 : coreCntQ + DIV_W'(1);
      sysCntQ  <= sysFire ? '0 : sysNext;
    end
  end

  assign strobes.coreFire = coreFire;
  assign strobes.sysFire  = sysFire;
  assign strobes.loadCfg  = sysFire;
  assign strobes.refFire  = refTick;

  // R3: core counter stays inside the applied core divide
  a_r3_core_bound: assert property (@(posedge clk) disable iff (!rstN)
    coreCntQ < effA);

  // R4: system counter never runs past divB plus one core period
  a_r4_sys_bound: assert property (@(posedge clk) disable iff (!rstN)
    sysCntQ < ({1'b0, divBQ} + {1'b0, effA}));

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [MULT_W-1:0] multSel,
  input  logic [DIV_W-1:0]  divASel,
  input  logic [DIV_W-1:0]  divBSel,
  input  logic              bypassSel,
  output logic [MULT_W-1:0] multQ,
  output logic [DIV_W-1:0]  divAQ,
  output logic [DIV_W-1:0]  divBQ,
  output logic              bypassQ,
  output logic              coreEn,
  output logic              sysEn,
  output logic              refTickOut,
  output logic              sysClamped
);

  logic [MULT_W-1:0] multFix;
  logic [DIV_W-1:0]  divAFix;
  logic [DIV_W-1:0]  divBFix;
  logic              clampNext;
  logic              runQ;

  always_comb begin
    multFix   = (multSel == '0) ? MULT_W'(1) : multSel;
    divAFix   = (divASel == '0) ? DIV_W'(1) : divASel;
    divBFix   = (divBSel == '0) ? DIV_W'(1) : divBSel;
    clampNext = !bypassSel && (divBFix < divAFix);
  end

  // applied settings: captured in reset and at each system boundary
  always_ff @(posedge clk) begin
    if (!rstN || strobes.loadCfg) begin
      multQ      <= multFix;
      divAQ      <= divAFix;
      divBQ      <= divBFix;
      bypassQ    <= bypassSel;
      sysClamped <= clampNext;
    end
  end

  always_ff @(posedge clk) begin
    runQ <= rstN;
    if (!rstN) begin
      coreEn     <= 1'b0;
      sysEn      <= 1'b0;
      refTickOut <= 1'b0;
    end else begin
      coreEn     <= strobes.coreFire;
      sysEn      <= strobes.sysFire;
      refTickOut <= strobes.refFire;
    end
  end

  // R1: enables are quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!coreEn && !sysEn));

  // R5: system pulse always lands on a core pulse
  a_r5_sys_on_core: assert property (@(posedge clk) disable iff (!rstN)
    sysEn |-> coreEn);

  // R7: in bypass the core enable tracks the input-clock tick
  a_r7_bypass_follow: assert property (@(posedge clk) disable iff (!rstN || !runQ)
    $past(bypassQ) |-> (coreEn == refTickOut));

  // R8: applied settings move only on a boundary strobe
  a_r8_hold_cfg: assert property (@(posedge clk) disable iff (!rstN || !runQ)
    !$past(strobes.loadCfg) |-> ($stable(multQ) && $stable(divAQ) &&
                                 $stable(divBQ) && $stable(bypassQ)));

  // R6: a clamp is never reported in bypass
  a_r6_clamp_mode: assert property (@(posedge clk) disable iff (!rstN)
    sysClamped |-> !bypassQ);

endmodule

// File: rtl/crc_ratio_ctrl.sv
module crc_ratio_ctrl
  import crc_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MULT_W-1:0] multSel,
  input  logic [DIV_W-1:0]  divCoreSel,
  input  logic [DIV_W-1:0]  divSysSel,
  input  logic              bypassSel,
  output logic              coreEn,
  output logic              sysEn,
  output logic              refTick,
  output logic              sysClamped
);

  strobe_t           strobes;
  logic [MULT_W-1:0] multQ;
  logic [DIV_W-1:0]  divAQ;
  logic [DIV_W-1:0]  divBQ;
  logic              bypassQ;
  logic              refRaw;
  logic              pllTick;

  crc_tickgen #(.MULT_W(MULT_W)) uTick (
    .clk     (clk),
    .rstN    (rstN),
    .multQ   (multQ),
    .refTick (refRaw),
    .pllTick (pllTick)
  );

  crc_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refRaw),
    .pllTick (pllTick),
    .divAQ   (divAQ),
    .divBQ   (divBQ),
    .bypassQ (bypassQ),
    .strobes (strobes)
  );

  crc_datapath #(.MULT_W(MULT_W), .DIV_W(DIV_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .multSel    (multSel),
    .divASel    (divCoreSel),
    .divBSel    (divSysSel),
    .bypassSel  (bypassSel),
    .multQ      (multQ),
    .divAQ      (divAQ),
    .divBQ      (divBQ),
    .bypassQ    (bypassQ),
    .coreEn     (coreEn),
    .sysEn      (sysEn),
    .refTickOut (refTick),
    .sysClamped (sysClamped)
  );

endmodule

// File: tb/crc_ratio_ctrl_test.sv
module crc_ratio_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] multSel = 5'd5;
  logic [3:0] divCoreSel = 4'd1;
  logic [3:0] divSysSel = 4'd1;
  logic       bypassSel = 1'b0;
  logic       coreEn, sysEn, refTick, sysClamped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic c; logic s; logic r; logic k; } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  crc_ratio_ctrl uut (
    .clk(clk), .rstN(rstN), .multSel(multSel), .divCoreSel(divCoreSel),
    .divSysSel(divSysSel), .bypassSel(bypassSel), .coreEn(coreEn),
    .sysEn(sysEn), .refTick(refTick), .sysClamped(sysClamped)
  );

  // ---- reference model (built from R1..R9), pushes expected outputs ----
  int mPhase, mAcc, mCore, mSys;
  int aMult, aDivA, aDivB;
  bit aByp;

  function automatic int fix(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic capture();
    aMult = fix(multSel); aDivA = fix(divCoreSel);
    aDivB = fix(divSysSel); aByp = bypassSel;
  endtask

  always @(posedge clk) begin
    exp_t e;
    if (!rstN) begin
      capture();
      mPhase = 0; mAcc = 0; mCore = 0; mSys = 0;
      e.c = 0; e.s = 0; e.r = 0;
    end else begin
      bit refT, pll, base, cf, sf;
      int sum, ea, nxt;
      refT = (mPhase == 31);
      sum = mAcc + aMult;
      pll = (sum >= 32);
      mAcc = sum % 32;
      mPhase = (mPhase + 1) % 32;
      base = aByp ? refT : pll;
      ea = aByp ? 1 : aDivA;
      cf = 0; sf = 0;
      if (base) begin
        if (mCore == ea - 1) begin cf = 1; mCore = 0; end
        else mCore++;
        nxt = mSys + 1;
        if (cf && nxt >= aDivB) begin sf = 1; mSys = 0; end
        else mSys = nxt;
      end
      if (sf) capture();
      e.c = cf; e.s = sf; e.r = refT;
    end
    e.k = !aByp && (aDivB < aDivA);
    expQ.push_back(e);
  end

  // ---- monitor: compare away from the active edge ----
  always @(negedge clk) begin
    if (expQ.size() > 0 && !done) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (coreEn !== e.c) begin errors++;
        $display("FAIL R3 coreEn got %b expected %b at %0t", coreEn, e.c, $time); end
      checks++;
      if (sysEn !== e.s) begin errors++;
        $display("FAIL R4 sysEn got %b expected %b at %0t", sysEn, e.s, $time); end
      checks++;
      if (refTick !== e.r) begin errors++;
        $display("FAIL R9 refTick got %b expected %b at %0t", refTick, e.r, $time); end
      checks++;
      if (sysClamped !== e.k) begin errors++;
        $display("FAIL R6 sysClamped got %b expected %b at %0t", sysClamped, e.k, $time); end
      if (sysEn === 1'b1) begin
        checks++;
        if (coreEn !== 1'b1) begin errors++;
          $display("FAIL R5 coreEn got %b expected 1 with sysEn", coreEn); end
      end
    end
  end

  // ---- driver helpers ----
  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic setCfg(input int m, input int a, input int b, input bit byp);
    @(negedge clk);
    multSel = 5'(m); divCoreSel = 4'(a); divSysSel = 4'(b); bypassSel = byp;
  endtask

  task automatic countWin(input int n, output int c, output int s);
    c = 0; s = 0;
    repeat (n) begin
      @(negedge clk);
      if (coreEn) c++;
      if (sysEn) s++;
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int c, s;
    repeat (4) @(negedge clk);
    chk("R1 coreEn in reset", coreEn, 0);
    chk("R1 sysEn in reset", sysEn, 0);
    rstN = 1'b1;

    // R2: multiplier 5, divides 1 -> 5 pulses per 32 cycles
    repeat (8) @(negedge clk);
    countWin(320, c, s);
    chk("R2 core pulses mult5", c, 50);
    chk("R4 sys pulses divB1", s, 50);

    // R2: multiplier 0 acts as 1
    setCfg(0, 1, 1, 0);
    repeat (100) @(negedge clk);
    countWin(320, c, s);
    chk("R2 core pulses mult0", c, 10);

    // R3: divide by 4 at multiplier 16
    setCfg(16, 4, 1, 0);
    repeat (100) @(negedge clk);
    countWin(256, c, s);
    chk("R3 core pulses div4", c, 32);
    chk("R4 sys pulses clamped to core", s, 32);

    // R3: core divide 0 acts as 1
    setCfg(16, 0, 1, 0);
    repeat (100) @(negedge clk);
    countWin(64, c, s);
    chk("R3 core pulses div0", c, 32);

    // R4: divA 3, divB 7 -> system period 9 ticks
    setCfg(16, 3, 7, 0);
    repeat (100) @(negedge clk);
    chk("R6 no clamp when divB>divA", sysClamped, 0);
    countWin(288, c, s);
    chk("R4 core pulses div3", c, 48);
    chk("R4 sys pulses period9", s, 16);

    // R6: divB below divA is clamped
    setCfg(16, 6, 2, 0);
    repeat (100) @(negedge clk);
    chk("R6 clamp flag", sysClamped, 1);
    countWin(192, c, s);
    chk("R6 core pulses div6", c, 16);
    chk("R6 sys equals core", s, 16);

    // R7: bypass -> core follows input tick, sys every 9 ticks
    setCfg(16, 5, 9, 1);
    repeat (100) @(negedge clk);
    chk("R7 no clamp in bypass", sysClamped, 0);
    countWin(288, c, s);
    chk("R7 core pulses in bypass", c, 9);
    chk("R7 sys pulses in bypass", s, 1);

    // R8: change mid-period, old rate holds until the boundary
    do @(negedge clk); while (!sysEn);
    repeat (2) @(negedge clk);
    multSel = 5'd31; divCoreSel = 4'd1; divSysSel = 4'd1; bypassSel = 1'b0;
    countWin(200, c, s);
    chk("R8 old rate kept mid-period", (c <= 7) ? 1 : 0, 1);
    repeat (400) @(negedge clk);
    countWin(32, c, s);
    chk("R8 new rate after boundary", c, 31);

    repeat (4) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

endmodule